// File: doc/BRIEF.md
# UART Interrupt Mask and Routing Unit

This unit holds the interrupt state of a UART: a raw status vector that collects events from the receive path, the transmit path, the receive-timeout detector, the modem control lines and the error detectors, plus an enable mask written by software. It combines the two and drives six registered interrupt lines. One line is the OR of every enabled source. The other five each serve one source group.

Software reaches the unit through a word-wide register port. It can read the raw and the masked status, load the enable mask, acknowledge events by writing ones to a clear register, and write a transmit data register. A write to that data register counts as a transmit event. The modem-status bits are not sticky. Each modem update pulse rebuilds them from the present line levels.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the enable mask, the raw status, all six interrupt lines and `bus_rvalid` are zero.
- R2: A read of the masked-status register (byte offset 0x0C) returns raw status AND enable mask, zero-extended to 32 bits.
- R3: A write to the clear register (offset 0x10) clears every raw bit whose written bit is one and leaves the others alone. A read of offset 0x10 returns zero.
- R4: A write to the mask register (offset 0x04) replaces the whole mask, which reads back at offset 0x04. Writes to the raw-status register (offset 0x08) and the masked-status register change nothing.
- R5: Source pulses set raw bits. The layout is receive at bit 0, transmit at bit 1, receive timeout at bit 2, and error inputs 0..3 at bits 7..10.
- R6: When a clear write and a set pulse target the same bit in the same cycle, the bit ends up set.
- R7: A modem update pulse loads raw bits 3..6 from `modem_lvl[3:0]`. Bit 3 is CTS, bit 4 DSR, bit 5 DCD and bit 6 RI. A low level clears its bit and a high level sets it.
- R8: Every write to the data register (offset 0x00) sets raw bit 1.
- R9: `irq_out[0]` is the OR of all masked bits. `irq_out[1]` through `irq_out[5]` follow, in order, masked receive, masked transmit, masked timeout, the OR of masked modem bits 3..6, and the OR of masked error bits 7..10. Each line changes one clock after the status or mask change that causes it.
- R10: A read request (`bus_valid` high, `bus_write` low) raises `bus_rvalid` for exactly the following cycle, with `bus_rdata` valid. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| ev_rx | input | 1 | Receive event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_rto | input | 1 | Receive-timeout event pulse |
| ev_err | input | ERR_N | Error event pulses |
| modem_upd | input | 1 | Modem flags changed; rebuild the modem status bits |
| modem_lvl | input | 4 | Current CTS, DSR, DCD, RI levels (bit 0 to bit 3) |
| irq_out | output | 6 | Combined line (bit 0) and five group lines |

## Verification
The main collision is an acknowledge write to the clear register arriving in the same cycle as a hardware event on the bit it clears. A second, milder case is a clear and a modem update landing together. The bench forces the first case by driving the clear write and an event pulse on the same clock edge, with other bits also selected for clearing. It then reads the raw status and checks that the event's bit survives while the other selected bits are gone. The scoreboard's expected value is built from the set-over-clear rule and does not depend on how the design orders its updates.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IRQ_LINES = 6;
  localparam int unsigned POS_RX    = 0;
  localparam int unsigned POS_TX    = 1;
  localparam int unsigned POS_RTO   = 2;
  localparam int unsigned POS_MS    = 3;
  localparam int unsigned MS_N      = 4;
  localparam int unsigned POS_ERR   = POS_MS + MS_N;
  localparam int unsigned OFS_DATA  = 0;
  localparam int unsigned OFS_MASK  = 4;
  localparam int unsigned OFS_RAW   = 8;
  localparam int unsigned OFS_MSKD  = 12;
  localparam int unsigned OFS_CLR   = 16;

  typedef enum logic [2:0] {
    LINE_ALL = 3'd0,
    LINE_RX  = 3'd1,
    LINE_TX  = 3'd2,
    LINE_RTO = 3'd3,
    LINE_MS  = 3'd4,
    LINE_ERR = 3'd5
  } line_e;
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_N = 4,
  parameter int unsigned ST_W  = POS_ERR + ERR_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx,
  input  logic             ev_tx,
  input  logic             ev_rto,
  input  logic [ERR_N-1:0] ev_err,
  input  logic             ms_upd,
  input  logic [MS_N-1:0]  ms_lvl,
  input  logic             clr_en,
  input  logic [ST_W-1:0]  clr_bits,
  output logic [ST_W-1:0]  raw_o
);
  logic [ST_W-1:0] raw_q;
  logic [ST_W-1:0] raw_d;
  logic [ST_W-1:0] set_vec;
  logic            raw_en;

  always_comb begin
    set_vec                     = '0;
    set_vec[POS_RX]             = ev_rx;
    set_vec[POS_TX]             = ev_tx;
    set_vec[POS_RTO]            = ev_rto;
    set_vec[ST_W-1:POS_ERR]     = ev_err;
    raw_d = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_bits;
    if (ms_upd) raw_d[POS_MS +: MS_N] = ms_lvl;
    raw_d  = raw_d | set_vec;
    raw_en = clr_en | ms_upd | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  // R6: a set pulse survives a clear of the same bit
  a_r6_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> raw_o[POS_RX]);
  a_r6_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> raw_o[POS_TX]);
  // R3: a lone clear removes all selected bits
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !ev_rx && !ev_tx && !ev_rto && (ev_err == '0) && !ms_upd)
    |=> ((raw_o & $past(clr_bits)) == '0));
  // R7: modem bits mirror the levels after an update
  a_r7_modem_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ms_upd |=> (raw_o[POS_MS +: MS_N] == $past(ms_lvl)));
endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ST_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ST_W-1:0]   raw_i,
  output logic [ST_W-1:0]   mask_o,
  output logic              clr_en_o,
  output logic [ST_W-1:0]   clr_bits_o,
  output logic              tx_wr_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              wr_req, rd_req;
  logic              hit_data, hit_mask, hit_raw, hit_mskd, hit_clr;
  logic [ST_W-1:0]   mask_q;
  logic              mask_en;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic              unused_wdata_hi;

  assign wr_req   = bus_valid & bus_write;
  assign rd_req   = bus_valid & ~bus_write;
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_raw  = (bus_addr == ADDR_W'(OFS_RAW));
  assign hit_mskd = (bus_addr == ADDR_W'(OFS_MSKD));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));

  assign mask_en    = wr_req & hit_mask;
  assign clr_en_o   = wr_req & hit_clr;
  assign clr_bits_o = bus_wdata[ST_W-1:0];
  assign tx_wr_o    = wr_req & hit_data;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ST_W];

  always_comb begin
    rdata_d = '0;
    if (hit_mask)      rdata_d[ST_W-1:0] = mask_q;
    else if (hit_raw)  rdata_d[ST_W-1:0] = raw_i;
    else if (hit_mskd) rdata_d[ST_W-1:0] = raw_i & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= bus_wdata[ST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign mask_o   = mask_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  // R4: a mask write replaces the whole mask
  a_r4_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && hit_mask) |=> (mask_o == $past(bus_wdata[ST_W-1:0])));
  // R10: read data valid exactly one cycle after a read request
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid_o);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid_o);
  // R2: masked status read returns raw AND mask
  a_r2_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hit_mskd) |=> (rdata_o[ST_W-1:0] == $past(raw_i & mask_o)));
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
#(
  parameter int unsigned ST_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ST_W-1:0]      raw_i,
  input  logic [ST_W-1:0]      mask_i,
  output logic [IRQ_LINES-1:0] irq_o
);
  function automatic logic [ST_W-1:0] group_sel(input line_e line);
    logic [ST_W-1:0] g;
    g = '0;
    case (line)
      LINE_ALL: g = '1;
      LINE_RX:  g[POS_RX]  = 1'b1;
      LINE_TX:  g[POS_TX]  = 1'b1;
      LINE_RTO: g[POS_RTO] = 1'b1;
      LINE_MS:  g[POS_MS +: MS_N] = '1;
      default:  g[ST_W-1:POS_ERR] = '1;
    endcase
    return g;
  endfunction

  logic [ST_W-1:0]      pend;
  logic [IRQ_LINES-1:0] irq_d;
  logic [IRQ_LINES-1:0] irq_q;

  assign pend = raw_i & mask_i;

  generate
    for (genvar l = 0; l < IRQ_LINES; l++) begin : g_line
      localparam logic [ST_W-1:0] SEL = group_sel(line_e'(l));
      assign irq_d[l] = |(pend & SEL);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9: combined line follows any masked bit, one cycle later
  a_r9_combined: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[0] == (|$past(raw_i & mask_i))));
  // R9: receive line
  a_r9_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[1] == $past(raw_i[POS_RX] & mask_i[POS_RX])));
  // R9: error line
  a_r9_err_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[5] == (|$past(raw_i[ST_W-1:POS_ERR] & mask_i[ST_W-1:POS_ERR]))));
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ERR_N  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  input  logic                 ev_rx,
  input  logic                 ev_tx,
  input  logic                 ev_rto,
  input  logic [ERR_N-1:0]     ev_err,
  input  logic                 modem_upd,
  input  logic [MS_N-1:0]      modem_lvl,
  output logic [IRQ_LINES-1:0] irq_out
);
  localparam int unsigned ST_W = POS_ERR + ERR_N;

  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic [ST_W-1:0] raw, mask, clr_bits;
  logic            clr_en, tx_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  uart_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(32), .ST_W(ST_W)) regif_i (
    .clk(clk), .rst_n(rst_core_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_i(raw), .mask_o(mask),
    .clr_en_o(clr_en), .clr_bits_o(clr_bits), .tx_wr_o(tx_wr),
    .rvalid_o(bus_rvalid), .rdata_o(bus_rdata)
  );

  uart_irq_status #(.ERR_N(ERR_N), .ST_W(ST_W)) status_i (
    .clk(clk), .rst_n(rst_core_n),
    .ev_rx(ev_rx), .ev_tx(ev_tx | tx_wr), .ev_rto(ev_rto), .ev_err(ev_err),
    .ms_upd(modem_upd), .ms_lvl(modem_lvl),
    .clr_en(clr_en), .clr_bits(clr_bits), .raw_o(raw)
  );

  uart_irq_route #(.ST_W(ST_W)) route_i (
    .clk(clk), .rst_n(rst_core_n),
    .raw_i(raw), .mask_i(mask), .irq_o(irq_out)
  );

  // R8: a data-register write marks the transmit bit
  a_r8_data_write_tx: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_DATA))) |=> raw[POS_TX]);
endmodule

// File: tb/uart_irq_router_tb_top.sv
module uart_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        ev_rx = 1'b0, ev_tx = 1'b0, ev_rto = 1'b0;
  logic [3:0]  ev_err = '0;
  logic        modem_upd = 1'b0;
  logic [3:0]  modem_lvl = '0;
  logic [5:0]  irq_out;

  int checks = 0;
  int errors = 0;
  logic [10:0] m_raw = '0;
  logic [10:0] m_mask = '0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #2.5 clk = ~clk;

  uart_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_rto(ev_rto),
    .ev_err(ev_err), .modem_upd(modem_upd), .modem_lvl(modem_lvl), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    case (a)
      8'h00: m_raw[1] = 1'b1;
      8'h04: m_mask = d[10:0];
      8'h10: m_raw = m_raw & ~d[10:0];
      default: ;
    endcase
  endtask

  // driver: issue a read and push its expected value to the scoreboard
  task automatic bus_rd(input logic [7:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    case (a)
      8'h04: e = {21'd0, m_mask};
      8'h08: e = {21'd0, m_raw};
      8'h0C: e = {21'd0, m_raw & m_mask};
      default: e = '0;
    endcase
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pulse(input logic rx, input logic tx, input logic rto, input logic [3:0] er);
    @(negedge clk);
    ev_rx = rx; ev_tx = tx; ev_rto = rto; ev_err = er;
    @(negedge clk);
    ev_rx = 1'b0; ev_tx = 1'b0; ev_rto = 1'b0; ev_err = '0;
    m_raw = m_raw | {er, 4'b0, rto, tx, rx};
  endtask

  task automatic modem(input logic [3:0] lvl);
    @(negedge clk);
    modem_lvl = lvl; modem_upd = 1'b1;
    @(negedge clk);
    modem_upd = 1'b0;
    m_raw[6:3] = lvl;
  endtask

  function automatic logic [5:0] exp_irq();
    logic [10:0] m;
    m = m_raw & m_mask;
    return {|m[10:7], |m[6:3], m[2], m[1], m[0], |m};
  endfunction

  task automatic chk_irq(input string req);
    @(negedge clk);
    check(req, {26'd0, irq_out}, {26'd0, exp_irq()});
  endtask

  // monitor: pops expected read data as responses appear (R10)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'd1, 32'd0);
      else check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {26'd0, irq_out}, 32'd0);
    check("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    bus_rd(8'h04, "R1 mask after reset");
    bus_rd(8'h08, "R1 raw after reset");
    // R5 receive event while masked off
    pulse(1'b1, 1'b0, 1'b0, 4'h0);
    bus_rd(8'h08, "R5 rx bit");
    chk_irq("R9 masked off lines low");
    // R4 mask write
    bus_wr(8'h04, 32'hFFFF_F7FF);
    bus_rd(8'h04, "R4 mask readback");
    chk_irq("R9 rx routed");
    // R5 more sources
    pulse(1'b0, 1'b1, 1'b1, 4'b0100);
    bus_rd(8'h08, "R5 tx rto err bits");
    chk_irq("R9 tx rto err lines");
    // R2 masked read
    bus_wr(8'h04, 32'h0000_0402);
    bus_rd(8'h0C, "R2 masked status");
    chk_irq("R9 partial mask");
    // R4 writes to status registers ignored
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h08, "R4 raw unchanged");
    bus_rd(8'h0C, "R4 masked unchanged");
    // R3 clear
    bus_wr(8'h10, 32'h0000_0405);
    bus_rd(8'h08, "R3 raw after clear");
    bus_rd(8'h10, "R3 clear reads zero");
    // R6 clear and set together
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h3;
    ev_rx = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ev_rx = 1'b0;
    m_raw = (m_raw & ~11'h3) | 11'h1;
    bus_rd(8'h08, "R6 set wins over clear");
    // R8 data write
    bus_wr(8'h00, 32'h41);
    bus_rd(8'h08, "R8 tx after data write");
    // R7 modem recompute
    bus_wr(8'h04, 32'h7FF);
    modem(4'b1010);
    bus_rd(8'h08, "R7 modem levels loaded");
    chk_irq("R9 modem line");
    modem(4'b0001);
    bus_rd(8'h08, "R7 modem levels replaced");
    modem(4'b0000);
    bus_wr(8'h10, 32'h7);
    chk_irq("R9 all clear");
    check("R7 modem line low", {31'd0, irq_out[4]}, 32'd0);
    // R9 one-cycle latency on mask change
    pulse(1'b0, 1'b0, 1'b0, 4'b0001);
    chk_irq("R9 err line");
    bus_wr(8'h04, 32'h0);
    check("R9 line holds one cycle", {26'd0, irq_out}, 32'h21);
    chk_irq("R9 line drops after mask");
    // R10 unmapped offset
    bus_rd(8'h40, "R10 unmapped reads zero");
    repeat (3) @(negedge clk);
    check("R10 all reads answered", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule